// File: doc/BRIEF.md
# Endpoint Zero Forced-NAK Control

This block holds the single firmware control bit that makes endpoint zero of a USB device controller answer every non-SETUP transaction with NAK. The NAK applies to requests the controller services by itself as well. Firmware reaches the bit through an 8-bit register port. The serial interface engine reports SETUP PIDs, entry into the status stage, bus reset, whether an endpoint zero transfer is running and whether an IN NAK handshake is in progress.

A firmware write does not always change the bit at once. A request to set the bit during a live transfer is parked as pending. It becomes effective only at a point where the engine is not reading request data. A request to clear the bit is held back while an IN token is being answered with NAK. Readback always shows the effective value. Firmware can therefore poll for a 1 before it touches the data of an automatically handled request.

Top module: `ep0_nak_ctrl`

## Requirements
- R1: The register reads as 8 bits. Bits 7..1 always read 0, and bit 0 reads the effective forced-NAK value, which also drives `nak_all_o`. After `rst_ni` the value is 00h.
- R2: A write with bit 0 = 1 while `xfer_busy_i` is low makes the effective bit 1 at the next clock edge.
- R3: A write of 1 while `xfer_busy_i` is high, after a SETUP has been seen, leaves the effective bit unchanged. The set is recorded as pending.
- R4: A pending set becomes effective at the clock edge on which `setup_pid_i` is high.
- R5: A pending set becomes effective at the clock edge on which `status_stage_i` is high.
- R6: While no SETUP has been seen since the last reset or bus reset, a write of 1 takes effect at the next edge even if `xfer_busy_i` is high.
- R7: A write with bit 0 = 0 while `in_nak_i` is low clears the effective bit at the next clock edge.
- R8: A write of 0 while `in_nak_i` is high leaves the bit at 1 for as long as `in_nak_i` stays high. The bit clears at the first edge on which `in_nak_i` is low.
- R9: A write of 0 before a pending set is committed cancels that set, so a later commit event leaves the bit at 0.
- R10: `bus_rst_i` clears the effective bit, any pending set and the record of a seen SETUP at the next edge.
- R11: A pending set becomes effective on the first edge on which `xfer_busy_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low controller reset |
| reg_wr_i | input | 1 | Firmware register write strobe |
| reg_wdata_i | input | 8 | Firmware write data (bit 0 used) |
| reg_rdata_o | output | 8 | Register readback |
| xfer_busy_i | input | 1 | Endpoint zero data transfer in progress |
| in_nak_i | input | 1 | IN token being answered with NAK |
| setup_pid_i | input | 1 | SETUP PID detected (pulse) |
| status_stage_i | input | 1 | Control transfer entering status stage (pulse) |
| bus_rst_i | input | 1 | USB bus reset detected (pulse) |
| nak_all_o | output | 1 | Effective forced-NAK to the engine |

## Verification
A stuck or stale pending-set flag shows on `nak_all_o` and readback bit 0 as a missing or spurious 1 at the first commit event after the write: the SETUP PID, the status stage, the end of the transfer or a post-reset write. A wrong SETUP-seen record changes whether a busy-time write commits on the next edge or waits. A lost deferred clear leaves the bit at 1 one cycle after `in_nak_i` falls. The bench keeps a behavioural model and compares both outputs on every clock, so any such divergence is seen within one cycle of the event that exposes it.

// File: rtl/ep0_nak_pkg.sv
package ep0_nak_pkg;
  parameter int unsigned REG_W   = 8;
  parameter int unsigned NAK_BIT = 0;
  localparam int unsigned PAD_W  = REG_W - 1;
endpackage

// File: rtl/ep0_nak_setup_track.sv
module ep0_nak_setup_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  input  logic setup_pid_i,
  output logic setup_seen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          setup_seen_o <= 1'b0;
    else if (bus_rst_i)   setup_seen_o <= 1'b0;
    else if (setup_pid_i) setup_seen_o <= 1'b1;
  end

  AST_SEEN_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_pid_i && !bus_rst_i |=> setup_seen_o); // R6
endmodule

// File: rtl/ep0_nak_set_path.sv
module ep0_nak_set_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  input  logic wr_set_i,
  input  logic wr_clr_i,
  input  logic window_i,
  output logic set_commit_o,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    if (wr_clr_i)      pend_d = 1'b0;
    else if (wr_set_i) pend_d = !window_i;
    else               pend_d = pend_q && !window_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (bus_rst_i) pend_q <= 1'b0;
    else                pend_q <= pend_d;
  end

  // a write of 0 wins over a commit landing in the same cycle
  assign set_commit_o = window_i && (wr_set_i || (pend_q && !wr_clr_i));
  assign pend_o       = pend_q;

  AST_CLR_CANCELS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> !pend_q); // R9
  AST_BUSRST_DROPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !pend_q); // R10
endmodule

// File: rtl/ep0_nak_clr_path.sv
module ep0_nak_clr_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  input  logic wr_set_i,
  input  logic wr_clr_i,
  input  logic in_nak_i,
  output logic clr_commit_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= 1'b0;
    else if (bus_rst_i) hold_q <= 1'b0;
    else if (wr_set_i)  hold_q <= 1'b0;
    else if (wr_clr_i)  hold_q <= in_nak_i;
    else                hold_q <= hold_q && in_nak_i;
  end

  assign clr_commit_o = !in_nak_i && (wr_clr_i || (hold_q && !wr_set_i));
endmodule

// File: rtl/ep0_nak_ctrl.sv
module ep0_nak_ctrl
  import ep0_nak_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             xfer_busy_i,
  input  logic             in_nak_i,
  input  logic             setup_pid_i,
  input  logic             status_stage_i,
  input  logic             bus_rst_i,
  output logic             nak_all_o
);
  logic wr_set, wr_clr, window, setup_seen, set_commit, clr_commit, pend, eff_q;

  assign wr_set = reg_wr_i &&  reg_wdata_i[NAK_BIT];
  assign wr_clr = reg_wr_i && !reg_wdata_i[NAK_BIT];
  // safe points where the engine is not reading request data
  assign window = !xfer_busy_i || !setup_seen || setup_pid_i || status_stage_i;

  ep0_nak_setup_track u_seen (
    .clk_i, .rst_ni, .bus_rst_i, .setup_pid_i, .setup_seen_o(setup_seen)
  );

  ep0_nak_set_path u_set (
    .clk_i, .rst_ni, .bus_rst_i, .wr_set_i(wr_set), .wr_clr_i(wr_clr),
    .window_i(window), .set_commit_o(set_commit), .pend_o(pend)
  );

  ep0_nak_clr_path u_clr (
    .clk_i, .rst_ni, .bus_rst_i, .wr_set_i(wr_set), .wr_clr_i(wr_clr),
    .in_nak_i, .clr_commit_o(clr_commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         eff_q <= 1'b0;
    else if (bus_rst_i)  eff_q <= 1'b0;
    else if (set_commit) eff_q <= 1'b1;
    else if (clr_commit) eff_q <= 1'b0;
  end

  assign nak_all_o   = eff_q;
  assign reg_rdata_o = {{PAD_W{1'b0}}, eff_q};

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:1] == '0); // R1
  AST_IDLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set && !xfer_busy_i && !bus_rst_i |=> nak_all_o); // R2
  AST_DEFER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eff_q && xfer_busy_i && setup_seen && !setup_pid_i && !status_stage_i
    |=> !nak_all_o); // R3
  AST_PEND_ON_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && setup_pid_i && !reg_wr_i && !bus_rst_i |=> nak_all_o); // R4
  AST_PEND_ON_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && status_stage_i && !reg_wr_i && !bus_rst_i |=> nak_all_o); // R5
  AST_CLR_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr && !in_nak_i && !bus_rst_i |=> !nak_all_o); // R7
  AST_CLR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_q && in_nak_i && !bus_rst_i |=> nak_all_o); // R8
  AST_BUSRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !nak_all_o); // R10
endmodule

// File: tb/ep0_nak_ctrl_tb_top.sv
module ep0_nak_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       xfer_busy_i = 1'b0, in_nak_i = 1'b0, setup_pid_i = 1'b0;
  logic       status_stage_i = 1'b0, bus_rst_i = 1'b0;
  logic       nak_all_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ep0_nak_ctrl dut_i (.*);

  // behavioural reference
  bit m_eff, m_pend, m_clrw, m_seen;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_eff = 0; m_pend = 0; m_clrw = 0; m_seen = 0;
    end else if (bus_rst_i) begin
      m_eff = 0; m_pend = 0; m_clrw = 0; m_seen = 0;
    end else begin
      bit safe;
      safe = !xfer_busy_i || !m_seen || setup_pid_i || status_stage_i;
      if (setup_pid_i) m_seen = 1;
      if (reg_wr_i && reg_wdata_i[0]) begin
        m_clrw = 0;
        if (safe) begin m_eff = 1; m_pend = 0; end
        else m_pend = 1;
      end else if (reg_wr_i) begin
        m_pend = 0;
        if (in_nak_i) m_clrw = 1;
        else begin m_eff = 0; m_clrw = 0; end
      end else begin
        if (m_pend && safe) begin m_eff = 1; m_pend = 0; end
        if (m_clrw && !in_nak_i) begin m_eff = 0; m_clrw = 0; end
      end
    end
  end

  always @(negedge clk_i) begin
    cycles++;
    if (rst_ni && !done) begin
      checks++;
      if (nak_all_o !== m_eff || reg_rdata_o !== {7'b0, m_eff}) begin
        fails++;
        $display("FAIL R1 model compare: nak=%0b rdata=%02h expected nak=%0b rdata=%02h",
                 nak_all_o, reg_rdata_o, m_eff, {7'b0, m_eff});
      end
    end
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected <= %0d", cycles, WATCHDOG);
      report();
    end
  end

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs after a negedge, return at the next negedge
  task automatic cyc(input bit wr, input bit wd, input bit busy, input bit nak,
                     input bit setup, input bit stat, input bit brst);
    reg_wr_i = wr; reg_wdata_i = {7'h55, wd}; xfer_busy_i = busy; in_nak_i = nak;
    setup_pid_i = setup; status_stage_i = stat; bus_rst_i = brst;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(nak_all_o, 1'b0, "R1 reset nak");
    checks++;
    if (reg_rdata_o !== 8'h00) begin
      fails++; $display("FAIL R1 reset rdata: actual=%02h expected=00", reg_rdata_o);
    end
    cyc(1,1,0,0,0,0,0); chk(nak_all_o, 1, "R2 idle set");
    checks++;
    if (reg_rdata_o !== 8'h01) begin
      fails++; $display("FAIL R1 readback: actual=%02h expected=01", reg_rdata_o);
    end
    cyc(1,0,0,0,0,0,0); chk(nak_all_o, 0, "R7 immediate clear");
    cyc(0,0,1,0,0,0,0); cyc(1,1,1,0,0,0,0); chk(nak_all_o, 1, "R6 set before SETUP");
    cyc(1,0,1,0,0,0,0); chk(nak_all_o, 0, "R7 clear");
    cyc(0,0,1,0,1,0,0);
    cyc(1,1,1,0,0,0,0); chk(nak_all_o, 0, "R3 deferred set");
    cyc(0,0,1,0,0,0,0); chk(nak_all_o, 0, "R3 still pending");
    cyc(0,0,1,0,1,0,0); chk(nak_all_o, 1, "R4 commit on SETUP");
    cyc(1,0,1,0,0,0,0); chk(nak_all_o, 0, "R7 clear busy");
    cyc(1,1,1,0,0,0,0); chk(nak_all_o, 0, "R3 deferred");
    cyc(0,0,1,0,0,1,0); chk(nak_all_o, 1, "R5 commit on status");
    cyc(1,0,1,1,0,0,0); chk(nak_all_o, 1, "R8 clear held");
    cyc(0,0,1,1,0,0,0); chk(nak_all_o, 1, "R8 clear still held");
    cyc(0,0,1,0,0,0,0); chk(nak_all_o, 0, "R8 clear after handshake");
    cyc(1,1,1,0,0,0,0); cyc(1,0,1,0,0,0,0); cyc(0,0,1,0,0,1,0);
    chk(nak_all_o, 0, "R9 cancelled set");
    cyc(1,1,1,0,0,0,0); chk(nak_all_o, 0, "R11 pending");
    cyc(0,0,0,0,0,0,0); chk(nak_all_o, 1, "R11 commit at transfer end");
    cyc(0,0,1,0,0,0,1); chk(nak_all_o, 0, "R10 bus reset clears");
    cyc(1,1,1,0,0,0,0); chk(nak_all_o, 1, "R6 set after bus reset");
    cyc(1,0,1,0,1,0,0); cyc(1,1,1,0,0,0,0); chk(nak_all_o, 0, "R3 pending before bus reset");
    cyc(0,0,1,0,0,0,1); cyc(0,0,1,0,0,0,0); chk(nak_all_o, 0, "R10 pending dropped");
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc($urandom_range(0,3) == 0, $urandom_range(0,1) == 1, r < 70,
          $urandom_range(0,4) == 0, $urandom_range(0,12) == 0,
          $urandom_range(0,12) == 0, $urandom_range(0,60) == 0);
    end
    cyc(0,0,0,0,0,0,0);
    report();
  end
endmodule